// File: doc/BRIEF.md
# Shadow Stack Return Verifier

This block runs the shadow-stack part of a return from an interrupt handler. A pulse on `start` hands it the current shadow stack pointer, the live code selector, the code base and instruction pointer, whether the target code runs in 64-bit mode, and a release mode. The block then reads three 64-bit records from the shadow stack through a simple request/acknowledge memory port. The record at pointer+16 is the saved selector, the one at pointer+8 is the saved linear return address, and the one at pointer+0 is the previous shadow stack pointer. It checks each record against the live context as soon as it arrives.

If every check passes, the restored pointer becomes the new shadow stack pointer. Depending on the release mode, the block may also free the busy token that sits just above the popped frame. It does this with a locked compare-and-swap: a read, then a write only when the read value matches. Any failed check ends the sequence at once with a control-protection or general-protection fault. In that case no further memory traffic occurs and the pointer keeps its starting value.

Top module: `shstk_ret_chk`

## Requirements
- R1: If `ssp_in` bits 2:0 are not all zero at start, the block raises `cp_fault` without any memory access, and `done` rises on the second cycle after the start cycle.
- R2: Records are read in the order pointer+16, pointer+8, pointer+0, one access at a time. `mem_req` and `mem_addr` hold until `mem_ack`, and each access takes two cycles. On success `new_ssp` equals the record read from pointer+0.
- R3: The record at pointer+16 must equal `cs_sel` zero-extended to 64 bits. Otherwise `cp_fault` is raised and no further access is made.
- R4: The record at pointer+8 must equal `cs_base + rip` taken modulo 2^64. Otherwise `cp_fault` is raised and no further access is made.
- R5: A restored pointer with bit 0 or bit 1 set raises `cp_fault`.
- R6: With `long_code` low, a restored pointer with any of bits 63:32 set raises `gp_fault`. The alignment fault of R5 takes precedence.
- R7: With `long_code` high, a restored pointer whose bits 63:47 are not all equal to bit 47 raises `gp_fault`.
- R8: `rel_mode` encodings are 0 for no release, 1 for always release, and 2 for release only when the restored pointer differs from `ssp_in`+24. Code 3 behaves like 0.
- R9: A release is a locked read at `ssp_in`+24. When the value read equals (`ssp_in`+24) with bit 0 set, a write of `ssp_in`+24 (bit 0 clear) to that address follows. `mem_lock` is high during both accesses, and writes occur only under lock.
- R10: If the locked read value does not match, no write is made, no fault is raised, and `new_ssp` is still the restored pointer.
- R11: On any fault there is no token access, and `new_ssp` equals `ssp_in`.
- R12: `done` is a one-cycle pulse. A `start` while a sequence runs is ignored. `new_ssp` and the fault flags hold after `done` until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a check sequence (sampled when idle) |
| ssp_in | input | 64 | Current shadow stack pointer |
| cs_sel | input | SEL_W | Live code selector |
| cs_base | input | 64 | Live code segment base |
| rip | input | 64 | Return instruction pointer |
| long_code | input | 1 | Target code is 64-bit |
| rel_mode | input | 2 | Token release mode (R8) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_lock | output | 1 | Atomic sequence in progress |
| mem_addr | output | 64 | Access byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with ack |
| mem_ack | input | 1 | Access complete |
| new_ssp | output | 64 | Resulting shadow stack pointer |
| cp_fault | output | 1 | Control-protection fault |
| gp_fault | output | 1 | General-protection fault |
| done | output | 1 | Sequence finished (pulse) |

## Verification
The stimulus makes the frame fail at each stage in turn: a misaligned pointer, then a bad selector, a bad return address, a misaligned restored pointer, and an out-of-range restored pointer. Comparing the access count and the latency across these cases shows exactly where the sequence stopped. Restored pointers are tried with and without `long_code`, one value on each side of the 32-bit and the sign-extension limits, which separates the two range rules. Release modes are run with a matching token, a cleared token, and a restored pointer equal to and different from the popped-frame top, which separates the compare-and-swap write from the no-write case and the conditional release from the unconditional one.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_RD_SEL, ST_RD_LIP, ST_RD_PREV, ST_CAS_RD, ST_CAS_WR, ST_FIN
   } ssr_state_e;

   typedef enum logic [1:0] {
      REL_NONE      = 2'd0,
      REL_ALWAYS    = 2'd1,
      REL_ON_SWITCH = 2'd2
   } ssr_rel_e;

   localparam int unsigned REC_BYTES = 8;
endpackage

// File: rtl/ssr_ptr_check.sv
module ssr_ptr_check #(
   parameter int unsigned VA_BITS = 48
) (
   input  logic [31:0] ptr_hi,
   input  logic [1:0]  ptr_lo,
   input  logic        long_code,
   output logic        align_bad,
   output logic        range_bad
);
   if (VA_BITS < 33 || VA_BITS > 64) begin : g_bad_va
      $error("ssr_ptr_check: VA_BITS must lie in 33..64");
   end

   assign align_bad = |ptr_lo;

   if (VA_BITS == 64) begin : g_full_va
      assign range_bad = !long_code && (|ptr_hi);
   end else begin : g_sext_va
      localparam int unsigned TOP_LO = VA_BITS - 33;
      logic [31-TOP_LO:0] upper;
      logic               canon_ok;
      assign upper     = ptr_hi[31:TOP_LO];
      assign canon_ok  = (&upper) || !(|upper);
      assign range_bad = long_code ? !canon_ok : (|ptr_hi);
   end
endmodule

// File: rtl/ssr_match.sv
module ssr_match #(
   parameter int unsigned SEL_W = 16
) (
   input  logic [63:0]      rec,
   input  logic [SEL_W-1:0] live_sel,
   input  logic [63:0]      live_lip,
   output logic             sel_ok,
   output logic             lip_ok
);
   if (SEL_W < 1 || SEL_W > 64) begin : g_bad_sel
      $error("ssr_match: SEL_W must lie in 1..64");
   end

   logic [63:0] sel_ext;
   if (SEL_W < 64) begin : g_zext
      assign sel_ext = {{(64-SEL_W){1'b0}}, live_sel};
   end else begin : g_full
      assign sel_ext = live_sel;
   end

   assign sel_ok = (rec == sel_ext);
   assign lip_ok = (rec == live_lip);
endmodule

// File: rtl/ssr_seq.sv
module ssr_seq
   import ssr_pkg::*;
#(
   parameter int unsigned SEL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [63:0]      ssp_in,
   input  logic [SEL_W-1:0] cs_sel,
   input  logic [63:0]      cs_base,
   input  logic [63:0]      rip,
   input  logic             long_code,
   input  logic [1:0]       rel_mode,
   input  logic             sel_ok,
   input  logic             lip_ok,
   input  logic             align_bad,
   input  logic             range_bad,
   output logic [SEL_W-1:0] lat_sel,
   output logic [63:0]      lat_lip,
   output logic             lat_long,
   output logic             mem_req,
   output logic             mem_we,
   output logic             mem_lock,
   output logic [63:0]      mem_addr,
   output logic [63:0]      mem_wdata,
   input  logic [63:0]      mem_rdata,
   input  logic             mem_ack,
   output logic [63:0]      new_ssp,
   output logic             cp_fault,
   output logic             gp_fault,
   output logic             done
);
   localparam logic [63:0] OFS_SEL = 64'(2 * REC_BYTES);
   localparam logic [63:0] OFS_LIP = 64'(REC_BYTES);
   localparam logic [63:0] OFS_TOK = 64'(3 * REC_BYTES);

   ssr_state_e  state;
   logic [63:0] orig_q, ssp_q, tok_q;
   logic [1:0]  rel_q;
   logic        want_rel;

   assign want_rel = (rel_q == REL_ALWAYS) ||
                     ((rel_q == REL_ON_SWITCH) && (mem_rdata != tok_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         orig_q   <= '0;
         ssp_q    <= '0;
         tok_q    <= '0;
         rel_q    <= '0;
         lat_sel  <= '0;
         lat_lip  <= '0;
         lat_long <= 1'b0;
         cp_fault <= 1'b0;
         gp_fault <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               orig_q   <= ssp_in;
               ssp_q    <= ssp_in;
               tok_q    <= ssp_in + OFS_TOK;
               rel_q    <= rel_mode;
               lat_sel  <= cs_sel;
               lat_lip  <= cs_base + rip;
               lat_long <= long_code;
               gp_fault <= 1'b0;
               if (ssp_in[2:0] != 3'b000) begin
                  cp_fault <= 1'b1;
                  state    <= ST_FIN;
               end else begin
                  cp_fault <= 1'b0;
                  state    <= ST_RD_SEL;
               end
            end
            ST_RD_SEL: if (mem_ack) begin
               if (!sel_ok) begin
                  cp_fault <= 1'b1;
                  state    <= ST_FIN;
               end else state <= ST_RD_LIP;
            end
            ST_RD_LIP: if (mem_ack) begin
               if (!lip_ok) begin
                  cp_fault <= 1'b1;
                  state    <= ST_FIN;
               end else state <= ST_RD_PREV;
            end
            ST_RD_PREV: if (mem_ack) begin
               if (align_bad) begin
                  cp_fault <= 1'b1;
                  state    <= ST_FIN;
               end else if (range_bad) begin
                  gp_fault <= 1'b1;
                  state    <= ST_FIN;
               end else begin
                  ssp_q <= mem_rdata;
                  state <= want_rel ? ST_CAS_RD : ST_FIN;
               end
            end
            ST_CAS_RD: if (mem_ack) begin
               state <= (mem_rdata == (tok_q | 64'd1)) ? ST_CAS_WR : ST_FIN;
            end
            ST_CAS_WR: if (mem_ack) state <= ST_FIN;
            ST_FIN: begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = 1'b1;
      mem_addr = tok_q;
      case (state)
         ST_RD_SEL:  mem_addr = orig_q + OFS_SEL;
         ST_RD_LIP:  mem_addr = orig_q + OFS_LIP;
         ST_RD_PREV: mem_addr = orig_q;
         ST_CAS_RD, ST_CAS_WR: mem_addr = tok_q;
         default:    mem_req = 1'b0;
      endcase
   end

   assign mem_we    = (state == ST_CAS_WR);
   assign mem_lock  = (state == ST_CAS_RD) || (state == ST_CAS_WR);
   assign mem_wdata = tok_q;
   assign new_ssp   = ssp_q;

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   wr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_lock);
   // R9
   tok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (!mem_wdata[0] && mem_wdata == mem_addr));
   // R11
   fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (cp_fault || gp_fault)) |-> (new_ssp == orig_q));
   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
   // R2
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[2:0] == 3'b000));
   // R6
   fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cp_fault && gp_fault));
endmodule

// File: rtl/shstk_ret_chk.sv
module shstk_ret_chk #(
   parameter int unsigned SEL_W   = 16,
   parameter int unsigned VA_BITS = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [63:0]      ssp_in,
   input  logic [SEL_W-1:0] cs_sel,
   input  logic [63:0]      cs_base,
   input  logic [63:0]      rip,
   input  logic             long_code,
   input  logic [1:0]       rel_mode,
   output logic             mem_req,
   output logic             mem_we,
   output logic             mem_lock,
   output logic [63:0]      mem_addr,
   output logic [63:0]      mem_wdata,
   input  logic [63:0]      mem_rdata,
   input  logic             mem_ack,
   output logic [63:0]      new_ssp,
   output logic             cp_fault,
   output logic             gp_fault,
   output logic             done
);
   logic             sel_ok, lip_ok, align_bad, range_bad, lat_long;
   logic [SEL_W-1:0] lat_sel;
   logic [63:0]      lat_lip;

   ssr_match #(.SEL_W(SEL_W)) u_match (
      .rec      (mem_rdata),
      .live_sel (lat_sel),
      .live_lip (lat_lip),
      .sel_ok   (sel_ok),
      .lip_ok   (lip_ok)
   );

   ssr_ptr_check #(.VA_BITS(VA_BITS)) u_ptr (
      .ptr_hi    (mem_rdata[63:32]),
      .ptr_lo    (mem_rdata[1:0]),
      .long_code (lat_long),
      .align_bad (align_bad),
      .range_bad (range_bad)
   );

   ssr_seq #(.SEL_W(SEL_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ssp_in    (ssp_in),
      .cs_sel    (cs_sel),
      .cs_base   (cs_base),
      .rip       (rip),
      .long_code (long_code),
      .rel_mode  (rel_mode),
      .sel_ok    (sel_ok),
      .lip_ok    (lip_ok),
      .align_bad (align_bad),
      .range_bad (range_bad),
      .lat_sel   (lat_sel),
      .lat_lip   (lat_lip),
      .lat_long  (lat_long),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_lock  (mem_lock),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack),
      .new_ssp   (new_ssp),
      .cp_fault  (cp_fault),
      .gp_fault  (gp_fault),
      .done      (done)
   );
endmodule

// File: tb/tb_shstk_ret_chk.sv
module tb_shstk_ret_chk;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] ssp_in = '0, cs_base = '0, rip = '0;
   logic [15:0] cs_sel = '0;
   logic        long_code = 1'b0;
   logic [1:0]  rel_mode = '0;
   logic        mem_req, mem_we, mem_lock, mem_ack;
   logic [63:0] mem_addr, mem_wdata, mem_rdata, new_ssp;
   logic        cp_fault, gp_fault, done;

   logic [63:0] mem [64];
   logic [63:0] exp_q[$];
   int n_rd = 0, n_wr = 0, mon_bad = 0;
   int tests = 0, fails = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   shstk_ret_chk dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ssp_in(ssp_in),
      .cs_sel(cs_sel), .cs_base(cs_base), .rip(rip), .long_code(long_code),
      .rel_mode(rel_mode), .mem_req(mem_req), .mem_we(mem_we),
      .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .new_ssp(new_ssp),
      .cp_fault(cp_fault), .gp_fault(gp_fault), .done(done)
   );

   function automatic int ix(input logic [63:0] a);
      return int'(a[8:3]);
   endfunction

   // bench memory: acknowledges one cycle after a request
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end else if (mem_req && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem[ix(mem_addr)];
         if (mem_we) mem[ix(mem_addr)] <= mem_wdata;
      end else begin
         mem_ack <= 1'b0;
      end
   end

   // per-clock monitor: access order, addresses, lock discipline
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_ack) begin
         if (mem_we) n_wr++; else n_rd++;
         if (mem_we && !mem_lock) mon_bad++;
         if (exp_q.size() == 0) mon_bad++;
         else if (exp_q.pop_front() != mem_addr) mon_bad++;
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic frame(input logic [63:0] s, input logic [63:0] ssel,
                        input logic [63:0] slip, input logic [63:0] sprev,
                        input logic [63:0] tok);
      mem[ix(s + 64'd16)] = ssel;
      mem[ix(s + 64'd8)]  = slip;
      mem[ix(s)]          = sprev;
      mem[ix(s + 64'd24)] = tok;
   endtask

   task automatic run_case(input string rq, input logic [63:0] s,
                           input logic [15:0] sel, input logic [63:0] base,
                           input logic [63:0] r, input logic lng,
                           input logic [1:0] mode, input bit poke);
      int n = 0;
      bit ecp = 0, egp = 0, ewr = 0, rel;
      logic [63:0] enew = s, p, tok_before, tok_after;
      int early = 0;
      tok_before = mem[ix(s + 64'd24)];
      exp_q.delete();
      if (s[2:0] != 0) ecp = 1;
      else begin
         n = 1; exp_q.push_back(s + 64'd16);
         if (mem[ix(s + 64'd16)] != {48'd0, sel}) ecp = 1;
         else begin
            n = 2; exp_q.push_back(s + 64'd8);
            if (mem[ix(s + 64'd8)] != base + r) ecp = 1;
            else begin
               n = 3; exp_q.push_back(s);
               p = mem[ix(s)];
               if (p[1:0] != 0) ecp = 1;
               else if (!lng && p[63:32] != 0) egp = 1;
               else if (lng && !(p[63:47] == 17'h0 || p[63:47] == 17'h1FFFF)) egp = 1;
               else begin
                  enew = p;
                  rel = (mode == 2'd1) || (mode == 2'd2 && p != s + 64'd24);
                  if (rel) begin
                     n = 4; exp_q.push_back(s + 64'd24);
                     if (tok_before == ((s + 64'd24) | 64'd1)) begin
                        n = 5; ewr = 1; exp_q.push_back(s + 64'd24);
                     end
                  end
               end
            end
         end
      end
      n_rd = 0; n_wr = 0; mon_bad = 0;
      ssp_in = s; cs_sel = sel; cs_base = base; rip = r;
      long_code = lng; rel_mode = mode; start = 1'b1;
      for (int k = 1; k <= 2 * n + 2; k++) begin
         @(negedge clk);
         if (k < 2 * n + 2 && done) early++;
         start = poke && (k == 2);
         if (poke && k == 2) ssp_in = 64'h5;
      end
      start = 1'b0;
      chk(early == 0, rq, "done before expected cycle", 64'(early), 0);
      chk(done == 1'b1, rq, "done at expected cycle", {63'd0, done}, 1);
      chk(cp_fault == ecp, rq, "cp_fault", {63'd0, cp_fault}, {63'd0, ecp});
      chk(gp_fault == egp, rq, "gp_fault", {63'd0, gp_fault}, {63'd0, egp});
      chk(new_ssp == enew, rq, "new_ssp", new_ssp, enew);
      chk(n_rd == ((n > 4) ? 4 : n), rq, "read count", 64'(n_rd), 64'((n > 4) ? 4 : n));
      chk(n_wr == int'(ewr), rq, "write count", 64'(n_wr), {63'd0, ewr});
      chk(mon_bad == 0 && exp_q.size() == 0, rq, "access sequence", 64'(mon_bad), 0);
      tok_after = mem[ix(s + 64'd24)];
      if (s[2:0] == 0)
         chk(tok_after == (ewr ? s + 64'd24 : tok_before), rq, "token word",
             tok_after, ewr ? s + 64'd24 : tok_before);
      // R12: idle afterwards, outputs held, no second run from a busy start
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (mem_req || done || new_ssp != enew || cp_fault != ecp) early++;
      end
      chk(early == 0, "R12", "hold after done", 64'(early), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog expired: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // reset state
      chk(!done && !mem_req && !cp_fault && !gp_fault && new_ssp == 0,
          "R12", "reset state", new_ssp, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 misaligned pointer
      run_case("R1", 64'h104, 16'h10, 64'h1000, 64'h2345, 0, 2'd1, 0);
      // R2 clean frame, no release
      frame(64'h100, 64'h10, 64'h3345, 64'h7FF0_0000, 64'h119);
      run_case("R2", 64'h100, 16'h10, 64'h1000, 64'h2345, 0, 2'd0, 0);
      // R3 selector with upper bits set is a mismatch; R11 no token access
      frame(64'h100, 64'h1_0010, 64'h3345, 64'h7FF0_0000, 64'h119);
      run_case("R3", 64'h100, 16'h10, 64'h1000, 64'h2345, 0, 2'd1, 0);
      // R4 return address off by one
      frame(64'h100, 64'h10, 64'h3346, 64'h7FF0_0000, 64'h119);
      run_case("R4", 64'h100, 16'h10, 64'h1000, 64'h2345, 0, 2'd1, 0);
      // R5 restored pointer bit 1 set (also high bits: R5 wins over R6)
      frame(64'h100, 64'h10, 64'h3345, 64'h1_0000_0002, 64'h119);
      run_case("R5", 64'h100, 16'h10, 64'h1000, 64'h2345, 0, 2'd1, 0);
      // R6 upper half set in non-64-bit code
      frame(64'h100, 64'h10, 64'h3345, 64'h1_0000_0000, 64'h119);
      run_case("R6", 64'h100, 16'h10, 64'h1000, 64'h2345, 0, 2'd1, 0);
      // R7 same pointer accepted in 64-bit code
      run_case("R7", 64'h100, 16'h10, 64'h1000, 64'h2345, 1, 2'd0, 0);
      // R7 bit 47 set without sign extension
      frame(64'h100, 64'h10, 64'h3345, 64'h0000_8000_0000_0000, 64'h119);
      run_case("R7", 64'h100, 16'h10, 64'h1000, 64'h2345, 1, 2'd0, 0);
      // R7 properly sign-extended high pointer
      frame(64'h100, 64'h10, 64'h3345, 64'hFFFF_8000_0000_1000, 64'h119);
      run_case("R7", 64'h100, 16'h10, 64'h1000, 64'h2345, 1, 2'd0, 0);
      // R9 release with busy token, start pulsed mid-run (R12)
      frame(64'h80, 64'h33, 64'h1_0000_0010, 64'h200, 64'h99);
      run_case("R9", 64'h80, 16'h33, 64'h1_0000_0000, 64'h10, 0, 2'd1, 1);
      // R10 token not busy: no write, still success
      frame(64'h80, 64'h33, 64'h1_0000_0010, 64'h200, 64'h98);
      run_case("R10", 64'h80, 16'h33, 64'h1_0000_0000, 64'h10, 0, 2'd1, 0);
      // R8 conditional release, restored pointer equals frame top
      frame(64'h100, 64'h10, 64'h3345, 64'h118, 64'h119);
      run_case("R8", 64'h100, 16'h10, 64'h1000, 64'h2345, 1, 2'd2, 0);
      // R8 conditional release, different pointer
      frame(64'h100, 64'h10, 64'h3345, 64'h40, 64'h119);
      run_case("R8", 64'h100, 16'h10, 64'h1000, 64'h2345, 1, 2'd2, 0);
      // R8 code 3 behaves as no release
      frame(64'h100, 64'h10, 64'h3345, 64'h40, 64'h119);
      run_case("R8", 64'h100, 16'h10, 64'h1000, 64'h2345, 1, 2'd3, 0);
      // R4 wrap of base plus ip modulo 2^64
      frame(64'h40, 64'h7, 64'h5, 64'h0, 64'h59);
      run_case("R4", 64'h40, 16'h7, 64'hFFFF_FFFF_FFFF_FFF8, 64'hD, 0, 2'd1, 0);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule